// File: doc/BRIEF.md
# Two-Level Interrupt Control Register

This block is the interrupt control and status register set of a small microcontroller core. A core register holds a global enable, a peripheral-group enable and enable/flag pairs for three core sources: a one-cycle timer-overflow pulse, an asynchronous external input that triggers on its rising edge, and a change detector watching a narrow group of upper I/O port pins. A companion pair of registers holds one enable bit and one flag bit for each source of the peripheral group. The peripheral group reaches the request only through its group enable.

Flags are sticky. They set on their events whatever the enable bits hold, so software can poll them. They clear only when software writes 0. If an event lands in the same cycle as a clearing write, the event wins. The core reaches the registers over a simple register bus with a combinational read path. The block drives one level-sensitive interrupt request.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset, all register addresses read 0x00 and `irq` is 0.
- R2: Address map. Address 0 is the core register: bit 7 global enable, bit 6 group enable, bit 5 timer enable, bit 4 external enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external flag, bit 0 port-change flag. Address 1 holds the peripheral enables and address 2 the peripheral flags, in bits NPER-1:0, with the upper bits reading 0. Address 3 reads the synchronized port pins in bits PORT_W-1:0. Addresses 0 to 2 are written whole, and `bus_rdata` always shows the register selected by `bus_addr`.
- R3: While the global enable is 0, `irq` is 0.
- R4: `irq` = global enable AND (timer pair OR external pair OR port pair OR (group enable AND any peripheral flag whose enable is set)), where a pair means flag AND enable.
- R5: While the group enable is 0, no peripheral flag can raise `irq`.
- R6: Flags set on their events whatever the state of their own enable and the global enable.
- R7: A set flag stays set until a bus write to its register clears it.
- R8: A hardware set and a write of 0 to the same flag in the same cycle leave the flag set.
- R9: `ext_in` passes through a two-stage synchronizer. A rising edge at its output sets the external flag, which reads 1 three clock edges after the input rises. A falling edge, or a level held high, does not set the flag.
- R10: A `tmr_ovf` pulse sets the timer flag at the same clock edge.
- R11: The port-change flag sets whenever the synchronized port pins differ from a stored reference. A read of address 3 (`bus_rd` high) loads the reference from the pins. After that read, a write of 0 clears the flag for good.
- R12: A pulse on a bit of `per_evt` sets the matching peripheral flag at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; qualifies port reads |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_in | input | 1 | Asynchronous external interrupt input |
| port_hi | input | PORT_W | Watched port pins |
| per_evt | input | NPER | Peripheral event pulses |
| irq | output | 1 | Interrupt request to the core |

## Verification
Register writes, timer pulses and peripheral pulses take effect at the next clock edge. `bus_rdata` and `irq` are combinational from the registers, so they are due in the cycle after the stimulus. The external and port paths cross two synchronizer stages and one flag register, so they are due three edges later. The bench drives inputs at the falling edge and samples just after it, before the next rising edge. A cycle-stepped model advances exactly one edge per sample. The directed checks test at the cycle before a result is due and at the cycle it is due.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W   = 8;
  localparam int B_GEN   = 7;
  localparam int B_GRPEN = 6;
  localparam int B_TMREN = 5;
  localparam int B_EXTEN = 4;
  localparam int B_CHGEN = 3;
  localparam int B_TMRFL = 2;
  localparam int B_EXTFL = 1;
  localparam int B_CHGFL = 0;

  typedef enum logic [1:0] {
    A_CORE = 2'd0,
    A_PEN  = 2'd1,
    A_PFLG = 2'd2,
    A_PORT = 2'd3
  } irq_addr_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
  parameter int PORT_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_in,
  input  logic [PORT_W-1:0] port_in,
  input  logic              snap_req,
  output logic              ext_rise,
  output logic              port_chg,
  output logic [PORT_W-1:0] port_s
);
  logic              ext_s;
  logic              ext_d_q;
  logic [PORT_W-1:0] ref_q;
  logic [PORT_W-1:0] ref_d;

  irq_sync #(.W(1), .STAGES(SYNC_N)) u_ext_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_in),
    .q     (ext_s)
  );

  irq_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_port_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (port_in),
    .q     (port_s)
  );

  always_comb begin
    ref_d    = snap_req ? port_s : ref_q;
    ext_rise = ext_s & ~ext_d_q;
    port_chg = |(port_s ^ ref_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_d_q <= 1'b0;
      ref_q   <= '0;
    end else begin
      ext_d_q <= ext_s;
      if (snap_req) ref_q <= ref_d;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctl_pkg::*;
#(
  parameter int NPER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_core,
  input  logic             wr_pen,
  input  logic             wr_pflg,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_tmr,
  input  logic             set_ext,
  input  logic             set_chg,
  input  logic [NPER-1:0]  pevt,
  output logic [REG_W-1:0] ctl_q,
  output logic [NPER-1:0]  pen_q,
  output logic [NPER-1:0]  pflg_q
);
  logic [REG_W-1:0] ctl_d;
  logic [NPER-1:0]  pen_d;
  logic [NPER-1:0]  pflg_d;
  logic             ctl_en;
  logic             pflg_en;
  logic [REG_W-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[B_TMRFL] = set_tmr;
    set_vec[B_EXTFL] = set_ext;
    set_vec[B_CHGFL] = set_chg;

    ctl_en  = wr_core | (|set_vec);
    ctl_d   = (wr_core ? wdata : ctl_q) | set_vec;

    pen_d   = wdata[NPER-1:0];

    pflg_en = wr_pflg | (|pevt);
    pflg_d  = (wr_pflg ? wdata[NPER-1:0] : pflg_q) | pevt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      pen_q  <= '0;
      pflg_q <= '0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (wr_pen)  pen_q  <= pen_d;
      if (pflg_en) pflg_q <= pflg_d;
    end
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int NPER   = 4,
  parameter int PORT_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tmr_ovf,
  input  logic              ext_in,
  input  logic [PORT_W-1:0] port_hi,
  input  logic [NPER-1:0]   per_evt,
  output logic              irq
);
  logic              rst_sync_n;
  logic              ext_rise;
  logic              port_chg;
  logic [PORT_W-1:0] port_s;
  logic              snap_req;
  logic              wr_core;
  logic              wr_pen;
  logic              wr_pflg;
  logic [REG_W-1:0]  ctl_q;
  logic [NPER-1:0]   pen_q;
  logic [NPER-1:0]   pflg_q;
  logic              core_hit;
  logic              grp_hit;
  irq_addr_e         sel;

  assign sel = irq_addr_e'(bus_addr);

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  always_comb begin
    wr_core  = bus_wr && (sel == A_CORE);
    wr_pen   = bus_wr && (sel == A_PEN);
    wr_pflg  = bus_wr && (sel == A_PFLG);
    snap_req = bus_rd && (sel == A_PORT);
  end

  irq_evt_detect #(.PORT_W(PORT_W), .SYNC_N(SYNC_N)) u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ext_in   (ext_in),
    .port_in  (port_hi),
    .snap_req (snap_req),
    .ext_rise (ext_rise),
    .port_chg (port_chg),
    .port_s   (port_s)
  );

  irq_regs #(.NPER(NPER)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_core (wr_core),
    .wr_pen  (wr_pen),
    .wr_pflg (wr_pflg),
    .wdata   (bus_wdata),
    .set_tmr (tmr_ovf),
    .set_ext (ext_rise),
    .set_chg (port_chg),
    .pevt    (per_evt),
    .ctl_q   (ctl_q),
    .pen_q   (pen_q),
    .pflg_q  (pflg_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      A_CORE: bus_rdata = ctl_q;
      A_PEN:  bus_rdata[NPER-1:0] = pen_q;
      A_PFLG: bus_rdata[NPER-1:0] = pflg_q;
      A_PORT: bus_rdata[PORT_W-1:0] = port_s;
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    core_hit = (ctl_q[B_TMREN] & ctl_q[B_TMRFL])
             | (ctl_q[B_EXTEN] & ctl_q[B_EXTFL])
             | (ctl_q[B_CHGEN] & ctl_q[B_CHGFL]);
    grp_hit  = ctl_q[B_GRPEN] & (|(pen_q & pflg_q));
    irq      = ctl_q[B_GEN] & (core_hit | grp_hit);
  end
endmodule

// File: rtl/irq_ctl_reg_chk.sv
module irq_ctl_reg_chk #(
  parameter int NPER = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [7:0]      bus_wdata,
  input logic            tmr_ovf,
  input logic [NPER-1:0] per_evt,
  input logic [7:0]      ctl_q,
  input logic [NPER-1:0] pflg_q,
  input logic            irq
);
  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[7] |-> !irq);

  // R5
  grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[6] && !(ctl_q[5] && ctl_q[2]) && !(ctl_q[4] && ctl_q[1])
     && !(ctl_q[3] && ctl_q[0])) |-> !irq);

  // R10
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ctl_q[2]);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd0) |=> ((ctl_q[2:0] & $past(ctl_q[2:0])) == $past(ctl_q[2:0])));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !bus_wdata[2] && tmr_ovf) |=> ctl_q[2]);

  // R12
  pflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_evt != '0) |=> ((pflg_q & $past(per_evt)) == $past(per_evt)));
endmodule

bind irq_ctl_reg irq_ctl_reg_chk #(.NPER(NPER)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tmr_ovf   (tmr_ovf),
  .per_evt   (per_evt),
  .ctl_q     (ctl_q),
  .pflg_q    (pflg_q),
  .irq       (irq)
);

// File: tb/irq_ctl_reg_bench.sv
module irq_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_ovf = 1'b0;
  logic       ext_in = 1'b0;
  logic [3:0] port_hi = 4'd0;
  logic [3:0] per_evt = 4'd0;
  logic       irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [7:0] m_ctl = 8'd0;
  logic [3:0] m_pen = 4'd0;
  logic [3:0] m_pflg = 4'd0;
  logic [3:0] m_ref = 4'd0;
  logic [3:0] m_p1 = 4'd0;
  logic [3:0] m_p2 = 4'd0;
  logic       m_x1 = 1'b0;
  logic       m_x2 = 1'b0;
  logic       m_x3 = 1'b0;
  logic       cur_ext = 1'b0;
  logic [3:0] cur_pins = 4'd0;
  logic [7:0] got_rd;
  logic       got_irq;

  always #10 clk = ~clk;

  irq_ctl_reg u_irq_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_ovf(tmr_ovf), .ext_in(ext_in), .port_hi(port_hi),
    .per_evt(per_evt), .irq(irq)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctl;
      2'd1:    return {4'd0, m_pen};
      2'd2:    return {4'd0, m_pflg};
      default: return {4'd0, m_p2};
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_ctl[7] & ((m_ctl[5] & m_ctl[2]) | (m_ctl[4] & m_ctl[1]) |
                       (m_ctl[3] & m_ctl[0]) | (m_ctl[6] & (|(m_pen & m_pflg))));
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d,
                     input logic e, input logic [3:0] p, input logic t, input logic [3:0] ev);
    logic [7:0] sets;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    ext_in = e; port_hi = p; tmr_ovf = t; per_evt = ev;
    cur_ext = e; cur_pins = p;
    #1;
    got_rd = bus_rdata;
    got_irq = irq;
    check(got_rd == exp_rd(a), "R2 read data", got_rd, exp_rd(a));
    check(got_irq == exp_irq(), "R4 irq", {7'd0, got_irq}, {7'd0, exp_irq()});
    sets = {5'd0, t, m_x2 & ~m_x3, m_p2 != m_ref};
    m_ctl = ((w && a == 2'd0) ? d : m_ctl) | sets;
    if (w && a == 2'd1) m_pen = d[3:0];
    m_pflg = ((w && a == 2'd2) ? d[3:0] : m_pflg) | ev;
    if (r && a == 2'd3) m_ref = m_p2;
    m_x3 = m_x2; m_x2 = m_x1; m_x1 = e;
    m_p2 = m_p1; m_p1 = p;
  endtask

  task automatic peek(input logic [1:0] a);
    cyc(1'b0, 1'b0, a, 8'd0, cur_ext, cur_pins, 1'b0, 4'd0);
  endtask

  task automatic chk_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
    peek(a);
    check(got_rd == exp, req, got_rd, exp);
  endtask

  task automatic chk_irq(input logic exp, input string req);
    peek(2'd0);
    check(got_irq == exp, req, {7'd0, got_irq}, {7'd0, exp});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d, cur_ext, cur_pins, 1'b0, 4'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_reg(2'd0, 8'h00, "R1 core reg");
    chk_reg(2'd1, 8'h00, "R1 pen reg");
    chk_reg(2'd2, 8'h00, "R1 pflg reg");
    chk_reg(2'd3, 8'h00, "R1 port reg");
    chk_irq(1'b0, "R1 irq");

    // R10 / R6: timer pulse sets flag with all enables off
    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 4'd0, 1'b1, 4'd0);
    chk_reg(2'd0, 8'h04, "R10 R6 timer flag");
    chk_irq(1'b0, "R3 no irq with global off");
    // R7: stays set
    peek(2'd1); peek(2'd2);
    chk_reg(2'd0, 8'h04, "R7 sticky timer flag");
    // R8: write 0 during pulse
    cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 4'd0, 1'b1, 4'd0);
    chk_reg(2'd0, 8'h04, "R8 set wins");
    wr(2'd0, 8'h00);
    chk_reg(2'd0, 8'h00, "R7 cleared by write");

    // R9: external edge timing
    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 4'd0, 1'b0, 4'd0);
    chk_reg(2'd0, 8'h00, "R9 not yet (1)");
    chk_reg(2'd0, 8'h00, "R9 not yet (2)");
    chk_reg(2'd0, 8'h02, "R9 flag on third edge");
    wr(2'd0, 8'h00);
    peek(2'd0); peek(2'd0);
    chk_reg(2'd0, 8'h00, "R9 held level no reset");
    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 4'd0, 1'b0, 4'd0);
    repeat (3) peek(2'd0);
    chk_reg(2'd0, 8'h00, "R9 falling edge ignored");

    // R11: port change, reference on read
    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 4'hA, 1'b0, 4'd0);
    chk_reg(2'd0, 8'h00, "R11 not yet (1)");
    chk_reg(2'd0, 8'h00, "R11 not yet (2)");
    chk_reg(2'd0, 8'h01, "R11 change flag");
    wr(2'd0, 8'h00);
    chk_reg(2'd0, 8'h01, "R11 mismatch persists");
    cyc(1'b0, 1'b1, 2'd3, 8'd0, 1'b0, 4'hA, 1'b0, 4'd0);
    check(got_rd == 8'h0A, "R11 port read", got_rd, 8'h0A);
    wr(2'd0, 8'h00);
    peek(2'd0);
    chk_reg(2'd0, 8'h00, "R11 cleared after reference load");

    // R12 / R5 / R3: peripheral group
    wr(2'd1, 8'h05);
    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 4'hA, 1'b0, 4'h3);
    chk_reg(2'd2, 8'h03, "R12 peripheral flags");
    wr(2'd0, 8'h80);
    chk_irq(1'b0, "R5 group disabled");
    wr(2'd0, 8'hC0);
    chk_irq(1'b1, "R4 group request");
    wr(2'd0, 8'h40);
    chk_irq(1'b0, "R3 global off masks group");
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);

    // R2 R4 R6 R7 R8: random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic w, r, e, t;
      logic [1:0] a;
      logic [7:0] d;
      logic [3:0] p, ev;
      w  = ($urandom_range(0, 3) == 0);
      r  = ($urandom_range(0, 3) == 0);
      a  = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      e  = ($urandom_range(0, 5) == 0) ? ~cur_ext : cur_ext;
      p  = ($urandom_range(0, 15) == 0) ? 4'($urandom) : cur_pins;
      t  = ($urandom_range(0, 7) == 0);
      ev = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'd0;
      cyc(w, r, a, d, e, p, t, ev);
    end

    summary();
  end
endmodule